// File: doc/BRIEF.md
# Indexed Response Byte Buffer

This block holds the data bytes of one serial-bus response in a small register file. A host bus reaches all of it through one byte-wide data port and one index register. The host first writes the index together with a hold bit. It then reads or writes bytes through the data port. With the hold bit at 0 the index steps forward after every data-port access and wraps from the top slot to slot 0. With the hold bit at 1 the index stays where it is, so the host rewrites it before each access.

A frame engine works on the same storage with a byte counter of its own. A start pulse clears the counter and picks a direction. In the receive direction the engine writes incoming bytes to slot 0, then slot 1, and so on. In the send direction it presents slot 0, then slot 1, and so on, advancing on each take pulse. The engine FSM has three named states:
- `ENG_IDLE`: waiting for a start pulse.
- `ENG_RECV`: storing bytes.
- `ENG_SEND`: presenting bytes.

Its transitions:
- `ENG_IDLE`→`ENG_RECV` on a start pulse with direction 0.
- `ENG_IDLE`→`ENG_SEND` on a start pulse with direction 1.
- `ENG_RECV`/`ENG_SEND`→`ENG_IDLE` after the byte in the last slot has been handled.
- `ENG_RECV`/`ENG_SEND`→`ENG_RECV`/`ENG_SEND` (restart) on a new start pulse.

A start pulse wins over a byte strobe that arrives in the same cycle.

In character mode the buffer is bypassed. A host write goes straight to an outgoing byte register and raises a one-cycle load strobe. A host read returns the last byte received on the character path. In this mode the index, the stored bytes and the engine do not change.

Top module: `respbuf_top`

## Requirements
- R1: After reset the index is 0, the hold bit is 0, the engine is idle (`eng_busy`=0), every buffer slot reads 0 and the received character byte is 0.
- R2: Outside character mode, `dat_rdata` shows the slot selected by the current index in the cycle of a read. A data-port write stores `dat_wdata` into that slot.
- R3: With the hold bit 0, every data-port read or write moves the index one slot forward after the access, from 7 to 0. A read returns the byte at the index as it was before the step.
- R4: With the hold bit 1, data-port accesses leave the index unchanged.
- R5: A host write of the index and hold bit takes effect on the next cycle and wins over a step in the same cycle. The index and hold bit change in no other way.
- R6: A start pulse with direction 0 puts the engine in receive. The k-th strobed byte goes to slot k, counting from 0. After the byte for slot 7 the engine is idle. Byte strobes in idle are ignored.
- R7: A start pulse with direction 1 puts the engine in send. `eng_tx_byte` shows slot k until the k-th take pulse. After the take of slot 7 the engine is idle.
- R8: The engine counter is independent of the host index. Engine activity never moves the host index.
- R9: In character mode, a host data write sets `uart_tx_byte` to the written value and pulses `uart_tx_load` for one cycle, starting on the next cycle. It changes neither a buffer slot nor the index.
- R10: In character mode, `dat_rdata` returns the byte from the most recent `uart_rx_valid` strobe.
- R11: When an engine store and a host data write hit the same slot in one cycle, the engine byte is kept.
- R12: In character mode, engine start, byte and take pulses are ignored: the engine state and counter do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_mode | input | 1 | 1 selects character (bypass) mode |
| sel_wr | input | 1 | Write strobe for index and hold bit |
| sel_idx | input | 3 | Index value to write |
| sel_hold | input | 1 | Hold bit to write (0 = auto-step) |
| sel_idx_q | output | 3 | Current host index |
| sel_hold_q | output | 1 | Current hold bit |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_rdata | output | 8 | Data-port read byte |
| eng_start | input | 1 | Start a response; clears engine counter |
| eng_dir | input | 1 | 0 = receive, 1 = send (sampled with start) |
| eng_rx_valid | input | 1 | Received byte strobe |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_take | input | 1 | Engine consumed the presented byte |
| eng_tx_byte | output | 8 | Byte presented for sending |
| eng_busy | output | 1 | Engine not idle |
| uart_rx_valid | input | 1 | Character received strobe |
| uart_rx_byte | input | 8 | Character received |
| uart_tx_byte | output | 8 | Outgoing character |
| uart_tx_load | output | 1 | Outgoing character loaded (one cycle) |

## Verification
A wrong index shows up at the ports at once: `sel_idx_q` can be read back, and the next data-port read returns a byte from the wrong slot. A wrong engine counter or state shows within one frame. Bytes land in shifted slots, `eng_tx_byte` presents out of order, or `eng_busy` drops early or late against the eight-byte count. A bypass leak in character mode shows as a changed slot or index once the mode is left, and the bench reads these back after such stimulus.

// File: rtl/respbuf_pkg.sv
package respbuf_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RECV = 2'd1,
        ENG_SEND = 2'd2
    } eng_state_t;
endpackage

// File: rtl/respbuf_index.sv
// Host index register with optional auto-step.
module respbuf_index #(
    parameter int NBYTES = 8,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             sel_hold,
    input  logic             access,
    output logic [IDX_W-1:0] idx_q,
    output logic             hold_q
);
    logic [IDX_W-1:0] idx_d;
    logic             hold_d;

    always_comb begin
        idx_d  = idx_q;
        hold_d = hold_q;
        if (sel_wr) begin
            idx_d  = sel_idx;
            hold_d = sel_hold;
        end else if (access && !hold_q) begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            idx_q  <= idx_d;
            hold_q <= hold_d;
        end
    end

    assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_wr && access && !hold_q) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_wr && hold_q) |=> $stable(idx_q));

    assert_sel_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (idx_q == $past(sel_idx) && hold_q == $past(sel_hold)));

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_wr && !access) |=> ($stable(idx_q) && $stable(hold_q)));
endmodule

// File: rtl/respbuf_store.sv
// Byte store: one host write port, one engine write port (engine wins), two read ports.
module respbuf_store #(
    parameter int NBYTES = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [IDX_W-1:0]  hw_addr,
    input  logic [DATA_W-1:0] hw_data,
    input  logic              ew_en,
    input  logic [IDX_W-1:0]  ew_addr,
    input  logic [DATA_W-1:0] ew_data,
    input  logic [IDX_W-1:0]  ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        logic eng_hit, host_hit;
        assign eng_hit  = ew_en && (ew_addr == IDX_W'(g));
        assign host_hit = hw_en && (hw_addr == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        mem[g] <= '0;
            else if (eng_hit)  mem[g] <= ew_data;
            else if (host_hit) mem[g] <= hw_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    assert_engine_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ew_en && hw_en && ew_addr == hw_addr) |=> (mem[$past(ew_addr)] == $past(ew_data)));
endmodule

// File: rtl/respbuf_engine.sv
// Frame-side sequencer: fills or drains slots 0..NBYTES-1 in order.
module respbuf_engine
    import respbuf_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NBYTES),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              dir,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_take,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]  cnt_q,
    output logic              busy
);
    eng_state_t       state_q, state_d;
    logic [IDX_W-1:0] cnt_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (enable) begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        state_d = dir ? ENG_SEND : ENG_RECV;
                        cnt_d   = '0;
                    end
                end
                ENG_RECV: begin
                    if (start) begin
                        state_d = dir ? ENG_SEND : ENG_RECV;
                        cnt_d   = '0;
                    end else if (rx_valid) begin
                        if (cnt_q == LAST) begin
                            state_d = ENG_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + IDX_W'(1);
                        end
                    end
                end
                ENG_SEND: begin
                    if (start) begin
                        state_d = dir ? ENG_SEND : ENG_RECV;
                        cnt_d   = '0;
                    end else if (tx_take) begin
                        if (cnt_q == LAST) begin
                            state_d = ENG_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = ENG_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        wr_en   = enable && (state_q == ENG_RECV) && rx_valid && !start;
        wr_addr = cnt_q;
        wr_data = rx_byte;
        busy    = (state_q != ENG_IDLE);
    end

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start) |=> (cnt_q == '0 && state_q != ENG_IDLE));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE) |-> (cnt_q == '0));

    assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: rtl/respbuf_top.sv
module respbuf_top #(
    parameter int NBYTES = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_mode,
    input  logic              sel_wr,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              sel_hold,
    output logic [IDX_W-1:0]  sel_idx_q,
    output logic              sel_hold_q,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rdata,
    input  logic              eng_start,
    input  logic              eng_dir,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_tx_take,
    output logic [DATA_W-1:0] eng_tx_byte,
    output logic              eng_busy,
    input  logic              uart_rx_valid,
    input  logic [DATA_W-1:0] uart_rx_byte,
    output logic [DATA_W-1:0] uart_tx_byte,
    output logic              uart_tx_load
);
    logic              buf_access;
    logic              host_wr;
    logic              ew_en;
    logic [IDX_W-1:0]  ew_addr;
    logic [DATA_W-1:0] ew_data;
    logic [IDX_W-1:0]  eng_cnt;
    logic [DATA_W-1:0] host_rd_data;
    logic [DATA_W-1:0] rx_char_q;

    assign buf_access = !uart_mode && (dat_rd || dat_wr);
    assign host_wr    = !uart_mode && dat_wr;

    respbuf_index #(.NBYTES(NBYTES)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .sel_idx  (sel_idx),
        .sel_hold (sel_hold),
        .access   (buf_access),
        .idx_q    (sel_idx_q),
        .hold_q   (sel_hold_q)
    );

    respbuf_engine #(.NBYTES(NBYTES), .DATA_W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!uart_mode),
        .start    (eng_start),
        .dir      (eng_dir),
        .rx_valid (eng_rx_valid),
        .rx_byte  (eng_rx_byte),
        .tx_take  (eng_tx_take),
        .wr_en    (ew_en),
        .wr_addr  (ew_addr),
        .wr_data  (ew_data),
        .cnt_q    (eng_cnt),
        .busy     (eng_busy)
    );

    respbuf_store #(.NBYTES(NBYTES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_en   (host_wr),
        .hw_addr (sel_idx_q),
        .hw_data (dat_wdata),
        .ew_en   (ew_en),
        .ew_addr (ew_addr),
        .ew_data (ew_data),
        .ra_addr (sel_idx_q),
        .ra_data (host_rd_data),
        .rb_addr (eng_cnt),
        .rb_data (eng_tx_byte)
    );

    // character-mode direct path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_char_q    <= '0;
            uart_tx_byte <= '0;
            uart_tx_load <= 1'b0;
        end else begin
            if (uart_rx_valid) rx_char_q <= uart_rx_byte;
            uart_tx_load <= uart_mode && dat_wr;
            if (uart_mode && dat_wr) uart_tx_byte <= dat_wdata;
        end
    end

    assign dat_rdata = uart_mode ? rx_char_q : host_rd_data;

    assert_char_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_mode && dat_wr) |=> (uart_tx_load && uart_tx_byte == $past(dat_wdata)));

    assert_char_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_mode && !sel_wr) |=> $stable(sel_idx_q));

    assert_char_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_rx_valid && uart_mode) |=> (!uart_mode || dat_rdata == $past(uart_rx_byte)));

    assert_engine_no_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_wr && !dat_rd && !dat_wr) |=> $stable(sel_idx_q));
endmodule

// File: tb/tb_respbuf_top.sv
module tb_respbuf_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_mode = 0, sel_wr = 0, sel_hold = 0;
    logic [2:0] sel_idx = '0;
    logic [2:0] sel_idx_q;
    logic       sel_hold_q;
    logic       dat_wr = 0, dat_rd = 0;
    logic [7:0] dat_wdata = '0, dat_rdata;
    logic       eng_start = 0, eng_dir = 0, eng_rx_valid = 0, eng_tx_take = 0;
    logic [7:0] eng_rx_byte = '0, eng_tx_byte;
    logic       eng_busy;
    logic       uart_rx_valid = 0;
    logic [7:0] uart_rx_byte = '0, uart_tx_byte;
    logic       uart_tx_load;

    int vectors = 0, miscompares = 0;
    logic [7:0] model [8];
    logic [7:0] got;

    always #2 clk = ~clk;

    respbuf_top dut (.*);

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_sel(int i, bit h);
        @(negedge clk); sel_wr = 1; sel_idx = 3'(i); sel_hold = h;
        @(negedge clk); sel_wr = 0;
    endtask

    task automatic host_write(logic [7:0] d);
        @(negedge clk); dat_wr = 1; dat_wdata = d;
        @(negedge clk); dat_wr = 0;
    endtask

    task automatic host_read(output logic [7:0] d);
        @(negedge clk); dat_rd = 1; #1 d = dat_rdata;
        @(negedge clk); dat_rd = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = 8'h00;
        #7 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 idx", sel_idx_q, 0);
        check("R1 hold", sel_hold_q, 0);
        check("R1 busy", eng_busy, 0);
        for (int a = 0; a < 8; a++) begin
            set_sel(a, 1);
            host_read(got);
            check("R1 slot", got, 0);
        end

        // R2/R3 write sweep from every start index with auto-step and wrap
        for (int s = 0; s < 8; s++) begin
            set_sel(s, 0);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v;
                v = 8'(((s * 8 + k) * 29 + 5));
                host_write(v);
                model[(s + k) % 8] = v;
                check("R3 step", sel_idx_q, (s + k + 1) % 8);
            end
            check("R3 wrap back to start", sel_idx_q, s);
            // R2/R4 read back each slot with hold
            for (int a = 0; a < 8; a++) begin
                set_sel(a, 1);
                host_read(got);
                check("R2 readback", got, model[a]);
                check("R4 hold idx", sel_idx_q, a);
            end
        end

        // R3 auto-step read returns old-index byte
        set_sel(5, 0);
        for (int k = 0; k < 8; k++) begin
            host_read(got);
            check("R3 read old idx", got, model[(5 + k) % 8]);
            check("R3 idx after read", sel_idx_q, (6 + k) % 8);
        end

        // R5 index write beats step in same cycle
        @(negedge clk); sel_wr = 1; sel_idx = 3'd2; sel_hold = 0; dat_rd = 1;
        @(negedge clk); sel_wr = 0; dat_rd = 0;
        check("R5 sel wins", sel_idx_q, 2);
        check("R5 hold", sel_hold_q, 0);

        // R6/R8 engine receive; host index parked at 3
        set_sel(3, 1);
        @(negedge clk); eng_start = 1; eng_dir = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); eng_start = 0;
            if (k > 0) check("R6 busy during", eng_busy, 1);
            eng_rx_valid = 1; eng_rx_byte = 8'(k * 53 + 11);
            model[k] = 8'(k * 53 + 11);
        end
        @(negedge clk); eng_rx_valid = 0;
        check("R6 idle after 8", eng_busy, 0);
        check("R8 host idx untouched", sel_idx_q, 3);
        // byte strobe while idle ignored
        @(negedge clk); eng_rx_valid = 1; eng_rx_byte = 8'hEE;
        @(negedge clk); eng_rx_valid = 0;
        for (int a = 0; a < 8; a++) begin
            set_sel(a, 1);
            host_read(got);
            check("R6 slot order", got, model[a]);
        end

        // R7 engine send drains in order
        set_sel(0, 0);
        for (int k = 0; k < 8; k++) begin
            host_write(8'(200 - k * 7));
            model[k] = 8'(200 - k * 7);
        end
        @(negedge clk); eng_start = 1; eng_dir = 1;
        @(negedge clk); eng_start = 0;
        for (int k = 0; k < 8; k++) begin
            check("R7 busy", eng_busy, 1);
            check("R7 tx byte", eng_tx_byte, model[k]);
            eng_tx_take = 1;
            @(negedge clk); eng_tx_take = 0;
        end
        check("R7 idle after 8", eng_busy, 0);

        // R11 engine store beats host write on same slot
        set_sel(0, 1);
        @(negedge clk); eng_start = 1; eng_dir = 0;
        @(negedge clk); eng_start = 0;
        eng_rx_valid = 1; eng_rx_byte = 8'hA5; dat_wr = 1; dat_wdata = 8'h3C;
        @(negedge clk); dat_wr = 0;
        for (int k = 1; k < 8; k++) begin
            eng_rx_byte = 8'(k);
            @(negedge clk);
        end
        eng_rx_valid = 0;
        host_read(got);
        check("R11 engine wins", got, 8'hA5);

        // R9/R10/R12 character mode
        set_sel(4, 0);
        set_sel(6, 1);
        host_read(got);
        model[6] = got;
        set_sel(2, 0);
        @(negedge clk); uart_mode = 1;
        #1 check("R10 rx char reset", dat_rdata, 0);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = 8'(k * 71 + 9);
            @(negedge clk); dat_wr = 1; dat_wdata = v;
            @(negedge clk); dat_wr = 0;
            check("R9 tx load", uart_tx_load, 1);
            check("R9 tx byte", uart_tx_byte, v);
            @(negedge clk);
            check("R9 load one cycle", uart_tx_load, 0);
            check("R9 idx frozen", sel_idx_q, 2);
            uart_rx_valid = 1; uart_rx_byte = 8'(v ^ 8'h5A);
            @(negedge clk); uart_rx_valid = 0;
            host_read(got);
            check("R10 rx char", got, v ^ 8'h5A);
        end
        @(negedge clk); eng_start = 1; eng_dir = 0;
        @(negedge clk); eng_start = 0;
        check("R12 start ignored", eng_busy, 0);
        @(negedge clk); uart_mode = 0;
        check("R9 idx after char", sel_idx_q, 2);
        #1 check("R9 slot kept", dat_rdata, 8'd2);

        finish_run();
    end
endmodule